// File: doc/BRIEF.md
# Credit Link Receiver with Parity Check

This block is the receive end of a source-synchronous link that uses credits for flow control. The link's forwarded clock is the block's only clock. On each rising edge, the block samples a message word, a valid line and one parity bit. It stores each accepted word in a small first-in first-out queue, and a local consumer drains that queue through a valid/ready handshake. The sender starts with as many credits as the queue has entries. Each time a word leaves the queue, the block flips a single credit-return line, and the sender counts these level changes to recover its credits.

An asynchronous link reset clears the queue at once. The release of that reset passes through a two-stage synchronizer, so the receiver only starts accepting words two forwarded-clock edges after the reset goes low. Two status bits stay set once raised, and only the link reset clears them. One marks a parity failure. The other marks a word that arrived while the queue was full.

Top module: `link_rx`

## Requirements
- R1: While `link_rst` is high, and until the second rising clock edge after it falls, `link_up` is 0, `q_valid` is 0, `credit_tgl` is 0, and both sticky flags are 0. `link_up` becomes 1 on that second edge.
- R2: A word is taken in only on a rising edge where `rx_vld` is 1 and `link_up` was already 1. In any other case the queue is left unchanged.
- R3: Words leave the queue in arrival order. The head word appears on `q_data` with `q_valid`=1 from the first falling edge after the edge that captured it.
- R4: `credit_tgl` changes level exactly once on each edge where `q_valid` and `q_ready` are both 1, and holds its level otherwise.
- R5: Parity is even over the message and its parity bit. A captured word for which the XOR of `rx_data` and `rx_par` is 1 sets `parity_err`, and the word is still stored.
- R6: Once set, `parity_err` stays 1 through later good words, until `link_rst` is asserted.
- R7: A word that arrives while the queue holds DEPTH entries, with no dequeue on the same edge, is dropped and sets `overflow_err`. `overflow_err` then stays 1 until `link_rst`, and the stored words are left intact.
- R8: When the queue is full, an arrival and a dequeue on the same edge are both carried out, and `overflow_err` is not set.
- R9: Raising `link_rst` clears `q_valid` and `link_up` with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded link clock |
| link_rst | input | 1 | Asynchronous link reset, active high |
| rx_data | input | MSG_W | Incoming message word |
| rx_par | input | 1 | Parity bit sent with the message |
| rx_vld | input | 1 | Message valid |
| credit_tgl | output | 1 | Credit return line, changes level once per dequeue |
| q_data | output | MSG_W | Head word of the receive queue |
| q_valid | output | 1 | Queue holds at least one word |
| q_ready | input | 1 | Consumer takes the head word |
| link_up | output | 1 | Receiver is out of reset |
| parity_err | output | 1 | Sticky parity failure flag |
| overflow_err | output | 1 | Sticky flag for a word that arrived while the queue was full |

## Verification
Several rules are checked by assertions on every cycle: the credit line changes level exactly on dequeue edges, the two error flags never clear while the link is up, a bad-parity capture always raises `parity_err`, and the occupancy never exceeds DEPTH. Other behaviour can only be shown by the bench's scenarios. These are the two-edge release timing, the order and content of the words that come out, the fact that a dropped word leaves the stored words untouched, the simultaneous write and read on a full queue, and the clear of the queue by the reset with no clock edge.

// File: rtl/link_rx.sv
module link_rx #(
  parameter int MSG_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             link_rst,
  input  logic [MSG_W-1:0] rx_data,
  input  logic             rx_par,
  input  logic             rx_vld,
  output logic             credit_tgl,
  output logic [MSG_W-1:0] q_data,
  output logic             q_valid,
  input  logic             q_ready,
  output logic             link_up,
  output logic             parity_err,
  output logic             overflow_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]       rst_sync;
  logic             irst;
  logic [MSG_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             full, deq, wr_try, wr_ok, bad_par;

  always_ff @(posedge clk or posedge link_rst)
    if (link_rst) rst_sync <= 2'b00;
    else          rst_sync <= {rst_sync[0], 1'b1};

  assign link_up = rst_sync[1];
  assign irst    = ~rst_sync[1];

  assign full    = (count == CW'(DEPTH));
  assign q_valid = (count != '0);
  assign q_data  = mem[rptr];
  assign deq     = q_valid & q_ready;
  assign wr_try  = rx_vld;
  assign wr_ok   = wr_try & (~full | deq);
  assign bad_par = ^{rx_data, rx_par};

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (!irst && wr_ok) mem[wptr] <= rx_data;

  always_ff @(posedge clk or posedge irst) begin
    if (irst) begin
      wptr         <= '0;
      rptr         <= '0;
      count        <= '0;
      credit_tgl   <= 1'b0;
      parity_err   <= 1'b0;
      overflow_err <= 1'b0;
    end else begin
      if (wr_ok) wptr <= nxt(wptr);
      if (deq) begin
        rptr       <= nxt(rptr);
        credit_tgl <= ~credit_tgl;
      end
      count <= count + CW'(wr_ok) - CW'(deq);
      if (wr_try && bad_par) parity_err <= 1'b1;
      if (wr_try && !wr_ok)  overflow_err <= 1'b1;
    end
  end

  assert_credit_flip_R4: assert property (@(posedge clk) disable iff (irst)
    deq |=> credit_tgl != $past(credit_tgl));
  assert_credit_hold_R4: assert property (@(posedge clk) disable iff (irst)
    !deq |=> $stable(credit_tgl));
  assert_parity_set_R5: assert property (@(posedge clk) disable iff (irst)
    (rx_vld && bad_par) |=> parity_err);
  assert_parity_sticky_R6: assert property (@(posedge clk) disable iff (irst)
    parity_err |=> parity_err);
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (irst)
    overflow_err |=> overflow_err);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (irst)
    count <= CW'(DEPTH));
  assert_full_pass_R8: assert property (@(posedge clk) disable iff (irst)
    (full && rx_vld && q_ready && !overflow_err) |=> !overflow_err);
endmodule

// File: tb/link_rx_tb.sv
module link_rx_tb_top;
  localparam int MSG_W = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic link_rst = 1'b1;
  logic [MSG_W-1:0] rx_data = '0;
  logic rx_par = 1'b0, rx_vld = 1'b0, q_ready = 1'b0;
  logic credit_tgl, q_valid, link_up, parity_err, overflow_err;
  logic [MSG_W-1:0] q_data;

  int errors = 0, checks = 0;
  logic exp_cred = 1'b0;

  always #4 clk = ~clk;

  link_rx #(.MSG_W(MSG_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .link_rst(link_rst), .rx_data(rx_data), .rx_par(rx_par),
    .rx_vld(rx_vld), .credit_tgl(credit_tgl), .q_data(q_data),
    .q_valid(q_valid), .q_ready(q_ready), .link_up(link_up),
    .parity_err(parity_err), .overflow_err(overflow_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reset_link();
    @(negedge clk);
    link_rst = 1'b1; rx_vld = 1'b0; q_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 link_up in reset", 32'(link_up), 0);
    chk("R1 q_valid in reset", 32'(q_valid), 0);
    chk("R1 credit in reset", 32'(credit_tgl), 0);
    chk("R1 flags in reset", {30'd0, parity_err, overflow_err}, 0);
    exp_cred = 1'b0;
    link_rst = 1'b0;
    rx_vld = 1'b1; rx_data = 16'hDEAD; rx_par = ^16'hDEAD;
    @(negedge clk);
    chk("R1 link_up after one edge", 32'(link_up), 0);
    @(negedge clk);
    chk("R1 link_up after two edges", 32'(link_up), 1);
    rx_vld = 1'b0;
    @(negedge clk);
    chk("R2 no capture before link_up", 32'(q_valid), 0);
  endtask

  task automatic send(input logic [MSG_W-1:0] d, input logic bad);
    rx_data = d; rx_par = bad ? ~(^d) : ^d; rx_vld = 1'b1;
    @(negedge clk);
    rx_vld = 1'b0;
  endtask

  task automatic pop(input string req, input logic [MSG_W-1:0] exp);
    chk({req, " q_valid"}, 32'(q_valid), 1);
    chk({req, " q_data"}, 32'(q_data), 32'(exp));
    q_ready = 1'b1;
    @(negedge clk);
    q_ready = 1'b0;
    exp_cred = ~exp_cred;
    chk("R4 credit toggles on dequeue", 32'(credit_tgl), 32'(exp_cred));
  endtask

  task automatic t_valid_gate();
    rx_data = 16'h1234; rx_par = ^16'h1234; rx_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no capture with rx_vld low", 32'(q_valid), 0);
    q_ready = 1'b1;
    @(negedge clk);
    q_ready = 1'b0;
    chk("R4 no toggle without dequeue", 32'(credit_tgl), 32'(exp_cred));
  endtask

  task automatic t_order();
    send(16'h0001, 1'b0);
    chk("R3 head visible after capture", 32'(q_data), 32'h0001);
    send(16'h00F0, 1'b0);
    send(16'hABCD, 1'b0);
    pop("R3", 16'h0001);
    pop("R3", 16'h00F0);
    pop("R3", 16'hABCD);
    chk("R3 queue empty", 32'(q_valid), 0);
    chk("R5 no error on good parity", 32'(parity_err), 0);
  endtask

  task automatic t_parity();
    send(16'h5A5A, 1'b1);
    chk("R5 parity_err set", 32'(parity_err), 1);
    pop("R5 bad word still stored", 16'h5A5A);
    send(16'h0F0F, 1'b0);
    pop("R6", 16'h0F0F);
    chk("R6 parity_err sticky", 32'(parity_err), 1);
    reset_link();
    chk("R6 parity_err cleared by link reset", 32'(parity_err), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) send(16'h100 + 16'(i), 1'b0);
    chk("R7 no overflow at exactly full", 32'(overflow_err), 0);
    send(16'hBEEF, 1'b0);
    chk("R7 overflow_err set", 32'(overflow_err), 1);
    for (int i = 0; i < DEPTH; i++) pop("R7 contents intact", 16'h100 + 16'(i));
    chk("R7 extra word dropped", 32'(q_valid), 0);
    chk("R7 overflow_err sticky", 32'(overflow_err), 1);
    reset_link();
  endtask

  task automatic t_full_simul();
    for (int i = 0; i < DEPTH; i++) send(16'h200 + 16'(i), 1'b0);
    chk("R8 head before simul", 32'(q_data), 32'h200);
    rx_data = 16'h2FF; rx_par = ^16'h2FF; rx_vld = 1'b1; q_ready = 1'b1;
    @(negedge clk);
    rx_vld = 1'b0; q_ready = 1'b0;
    exp_cred = ~exp_cred;
    chk("R8 no overflow", 32'(overflow_err), 0);
    chk("R4 credit toggles on simul dequeue", 32'(credit_tgl), 32'(exp_cred));
    for (int i = 1; i < DEPTH; i++) pop("R8", 16'h200 + 16'(i));
    pop("R8 simul word kept", 16'h2FF);
    chk("R8 queue empty", 32'(q_valid), 0);
  endtask

  task automatic t_async();
    send(16'h0A0A, 1'b0);
    send(16'h0B0B, 1'b0);
    chk("R9 data queued", 32'(q_valid), 1);
    #1 link_rst = 1'b1;
    #1;
    chk("R9 q_valid cleared without edge", 32'(q_valid), 0);
    chk("R9 link_up cleared without edge", 32'(link_up), 0);
    reset_link();
    chk("R9 queue empty after reset", 32'(q_valid), 0);
  endtask

  initial begin
    reset_link();
    t_valid_gate();
    t_order();
    t_parity();
    t_overflow();
    t_full_simul();
    t_async();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule